// File: doc/BRIEF.md
# Power-Down Release Output Sequencer

This block sits on the serial output side of an audio converter and decides when sample data may leave it. A single active-low power control input governs it. While that input is low, every register is held cleared, the sample output and ready flag are low, and in master mode the outgoing frame and bit clocks are held low. When the input goes high, the block waits for the frame clock to run. It counts frame periods by their rising edges and replaces every sample with zero until the converter's start-up interval has passed. After that it passes samples through unchanged.

The start-up interval depends on the clocking role. It is 4132 frame periods when the block receives its clocks (slave) and 4129 frame periods when it generates them (master). Driving the power control low at any point clears the count at once, so the next release starts the full interval again.

Top module: `pd_release_seq`

## Requirements
- R1: While `pwr_on_i` is low, `sample_o` is all zero and `ready_o` is low. Both respond combinationally, with no clock edge needed.
- R2: In master mode (`master_i` = 1), `frm_clk_o` and `bit_clk_o` are low while `pwr_on_i` is low. They follow `frm_clk_i` and `bit_clk_i` while `pwr_on_i` is high.
- R3: In slave mode (`master_i` = 0), the first 4132 frames after release are output as zero with `ready_o` low. A frame starts on a rising edge of `frm_clk_i`.
- R4: In master mode, the first 4129 frames after release are output as zero with `ready_o` low.
- R5: Only rising edges of `frm_clk_i` that occur after release are counted. A frame clock that is already high at release does not count as an edge, and a stopped frame clock keeps the output muted indefinitely.
- R6: Pulling `pwr_on_i` low partway through the count discards it. After the next release, the full interval is muted again.
- R7: On the rising frame edge that follows the last muted frame, `ready_o` goes high on the next `clk` edge. From then on `sample_o` equals `sample_i`, and `ready_o` stays high while powered.
- R8: In slave mode, `frm_clk_o` and `bit_clk_o` are held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the frame clock |
| pwr_on_i | input | 1 | Power control: low = powered down, high = operating |
| master_i | input | 1 | 1 = master clocking role, 0 = slave |
| frm_clk_i | input | 1 | Frame clock (one period per stereo frame) |
| bit_clk_i | input | 1 | Serial bit clock |
| sample_i | input | DW (24) | Sample data from the converter |
| sample_o | output | DW (24) | Gated sample data |
| frm_clk_o | output | 1 | Frame clock out, driven only in master mode |
| bit_clk_o | output | 1 | Bit clock out, driven only in master mode |
| ready_o | output | 1 | High once real samples pass through |

## Verification
Power-down and the master/slave clock gating act combinationally, so the bench checks them one time unit after it changes the inputs. A frame edge is sampled on the first `clk` rising edge after `frm_clk_i` rises, and the ready register updates on that same edge. The bench therefore changes `frm_clk_i` on falling edges of `clk` and checks `ready_o` and `sample_o` on the next falling edge. It checks once after the final muted frame, where the outputs must still be zero, and once after the following frame edge, where data must be released. All other observations are also made on falling edges, away from the sampling edge.

// File: rtl/pd_release_seq.sv
module pd_release_seq #(
  parameter int DW = 24,
  parameter int SLV_FRAMES = 4132,
  parameter int MST_FRAMES = 4129
) (
  input  logic          clk,
  input  logic          pwr_on_i,
  input  logic          master_i,
  input  logic          frm_clk_i,
  input  logic          bit_clk_i,
  input  logic [DW-1:0] sample_i,
  output logic [DW-1:0] sample_o,
  output logic          frm_clk_o,
  output logic          bit_clk_o,
  output logic          ready_o
);
  localparam int MAXF = (SLV_FRAMES > MST_FRAMES) ? SLV_FRAMES : MST_FRAMES;
  localparam int CW = $clog2(MAXF + 1);

  logic          frm_q;
  logic          live_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;
  logic          frm_rise;

  assign limit    = master_i ? CW'(MST_FRAMES) : CW'(SLV_FRAMES);
  assign frm_rise = frm_clk_i & ~frm_q;

  always_ff @(posedge clk or negedge pwr_on_i) begin
    if (!pwr_on_i) begin
      frm_q  <= 1'b1;
      cnt_q  <= '0;
      live_q <= 1'b0;
    end else begin
      frm_q <= frm_clk_i;
      if (frm_rise && !live_q) begin
        if (cnt_q == limit) live_q <= 1'b1;
        else                cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign ready_o   = live_q & pwr_on_i;
  assign sample_o  = ready_o ? sample_i : '0;
  assign frm_clk_o = master_i & pwr_on_i & frm_clk_i;
  assign bit_clk_o = master_i & pwr_on_i & bit_clk_i;
endmodule

// File: rtl/pd_release_seq_chk.sv
module pd_release_seq_chk #(
  parameter int DW = 24,
  parameter int SLV_FRAMES = 4132,
  parameter int MST_FRAMES = 4129
) (
  input logic          clk,
  input logic          pwr_on_i,
  input logic          master_i,
  input logic          frm_clk_i,
  input logic [DW-1:0] sample_i,
  input logic [DW-1:0] sample_o,
  input logic          frm_clk_o,
  input logic          bit_clk_o,
  input logic          ready_o
);
  localparam int MAXF = (SLV_FRAMES > MST_FRAMES) ? SLV_FRAMES : MST_FRAMES;
  localparam int SW = $clog2(MAXF + 2) + 1;

  logic          prev_q;
  logic [SW-1:0] seen_q;

  always_ff @(posedge clk or negedge pwr_on_i) begin
    if (!pwr_on_i) begin
      prev_q <= 1'b1;
      seen_q <= '0;
    end else begin
      prev_q <= frm_clk_i;
      if (frm_clk_i && !prev_q && seen_q <= SW'(MAXF)) seen_q <= seen_q + 1'b1;
    end
  end

  // R1
  pd_quiet_chk: assert property (@(posedge clk)
    !pwr_on_i |-> (sample_o == '0 && !ready_o));

  // R2
  clk_gate_chk: assert property (@(posedge clk)
    !pwr_on_i |-> (!frm_clk_o && !bit_clk_o));

  // R8
  slave_clk_low_chk: assert property (@(posedge clk)
    !master_i |-> (!frm_clk_o && !bit_clk_o));

  // R3
  slave_mute_chk: assert property (@(posedge clk) disable iff (!pwr_on_i)
    !master_i |-> (ready_o == (seen_q > SW'(SLV_FRAMES))));

  // R4
  master_mute_chk: assert property (@(posedge clk) disable iff (!pwr_on_i)
    master_i |-> (ready_o == (seen_q > SW'(MST_FRAMES))));

  // R7
  ready_hold_chk: assert property (@(posedge clk) disable iff (!pwr_on_i)
    ready_o |=> ready_o);

  // R7
  pass_through_chk: assert property (@(posedge clk) disable iff (!pwr_on_i)
    ready_o |-> (sample_o == sample_i));
endmodule

bind pd_release_seq pd_release_seq_chk #(
  .DW(DW), .SLV_FRAMES(SLV_FRAMES), .MST_FRAMES(MST_FRAMES)
) u_chk (
  .clk(clk), .pwr_on_i(pwr_on_i), .master_i(master_i), .frm_clk_i(frm_clk_i),
  .sample_i(sample_i), .sample_o(sample_o), .frm_clk_o(frm_clk_o),
  .bit_clk_o(bit_clk_o), .ready_o(ready_o)
);

// File: tb/pd_release_seq_bench.sv
`timescale 1ns/1ps
module pd_release_seq_bench;
  localparam int DW = 24;
  localparam int SLV = 4132;
  localparam int MST = 4129;

  logic clk = 1'b0;
  logic pwr_on = 1'b0, master = 1'b0, frm = 1'b0, bck = 1'b0;
  logic [DW-1:0] smp = '0;
  logic [DW-1:0] smp_o;
  logic frm_o, bck_o, rdy;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pd_release_seq u_pd_release_seq (
    .clk(clk), .pwr_on_i(pwr_on), .master_i(master), .frm_clk_i(frm),
    .bit_clk_i(bck), .sample_i(smp), .sample_o(smp_o), .frm_clk_o(frm_o),
    .bit_clk_o(bck_o), .ready_o(rdy)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic frames(int n);
    for (int i = 0; i < n; i++) begin
      frm = 1'b1;
      repeat (4) @(negedge clk);
      frm = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic t_powered_down;
    @(negedge clk);
    pwr_on = 1'b0; master = 1'b1; frm = 1'b1; bck = 1'b1; smp = 24'h7E1234;
    #1;
    check("R1 data", 32'(smp_o), 32'h0);
    check("R1 ready", 32'(rdy), 32'h0);
    check("R2 frm low", 32'(frm_o), 32'h0);
    check("R2 bit low", 32'(bck_o), 32'h0);
    pwr_on = 1'b1; #1;
    check("R2 frm follows", 32'(frm_o), 32'h1);
    check("R2 bit follows", 32'(bck_o), 32'h1);
    pwr_on = 1'b0; frm = 1'b0; bck = 1'b0;
  endtask

  task automatic t_slave;
    @(negedge clk);
    master = 1'b0; frm = 1'b1; bck = 1'b1; smp = 24'hA5C3F1;
    pwr_on = 1'b1;
    repeat (200) @(negedge clk);
    check("R5 stalled high", 32'(rdy), 32'h0);
    check("R8 frm low", 32'(frm_o), 32'h0);
    check("R8 bit low", 32'(bck_o), 32'h0);
    frm = 1'b0;
    repeat (4) @(negedge clk);
    frames(100);
    check("R3 early mute", 32'(smp_o), 32'h0);
    frames(SLV - 100);
    check("R3 last muted ready", 32'(rdy), 32'h0);
    check("R3 last muted data", 32'(smp_o), 32'h0);
    frm = 1'b1;
    @(negedge clk);
    check("R7 ready", 32'(rdy), 32'h1);
    check("R7 data", 32'(smp_o), 32'hA5C3F1);
    smp = 24'h00FF01; #1;
    check("R7 follows", 32'(smp_o), 32'h00FF01);
    frm = 1'b0;
    repeat (50) @(negedge clk);
    check("R7 holds", 32'(rdy), 32'h1);
    pwr_on = 1'b0; #1;
    check("R1 immediate", 32'(smp_o), 32'h0);
  endtask

  task automatic t_master;
    @(negedge clk);
    master = 1'b1; frm = 1'b0; smp = 24'h3C3C3C;
    pwr_on = 1'b1;
    repeat (4) @(negedge clk);
    frames(MST);
    check("R4 last muted", 32'(rdy), 32'h0);
    frm = 1'b1;
    @(negedge clk);
    check("R4 ready", 32'(rdy), 32'h1);
    check("R4 data", 32'(smp_o), 32'h3C3C3C);
    check("R2 frm passes", 32'(frm_o), 32'h1);
    frm = 1'b0;
    repeat (4) @(negedge clk);
    pwr_on = 1'b0;
  endtask

  task automatic t_abort;
    @(negedge clk);
    master = 1'b0; frm = 1'b0; smp = 24'h123456;
    pwr_on = 1'b1;
    repeat (4) @(negedge clk);
    frames(2000);
    frm = 1'b1;
    repeat (2) @(negedge clk);
    pwr_on = 1'b0; #1;
    check("R6 down data", 32'(smp_o), 32'h0);
    frm = 1'b0;
    repeat (4) @(negedge clk);
    pwr_on = 1'b1;
    repeat (4) @(negedge clk);
    frames(SLV);
    check("R6 full restart", 32'(rdy), 32'h0);
    frm = 1'b1;
    @(negedge clk);
    check("R6 ready after restart", 32'(rdy), 32'h1);
    frm = 1'b0;
    pwr_on = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset data", 32'(smp_o), 32'h0);
    check("R1 reset ready", 32'(rdy), 32'h0);
    t_powered_down();
    t_slave();
    t_master();
    t_abort();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule